// File: doc/BRIEF.md
# Shared-Bus Address Capture and Port Decoder

This block sits beside a processor that uses one 8-bit bus for both addresses and data. A 2-bit slot indication tells it which part of a bus cycle is on the wires. The block captures the low address byte in the low-address slot. It captures the upper six address bits, together with a two-bit cycle-kind field, in the high-address slot. From then on it drives a steady 14-bit memory address, so memory can be reached during the data slot that follows.

During the data slot the block raises exactly one strobe, chosen by the cycle kind:

- a memory read strobe,
- a memory write strobe,
- an interrupt-acknowledge strobe, or
- one select line out of a port space that is kept apart from memory.

In that port space, numbers 0 to 7 are inputs and numbers 8 to 31 are outputs. The port number is the low five bits of the captured address.

Top module: `abus_demux`

## Requirements
- R1: While reset is held, and after it is released until a cycle completes, the address output is 0 and every strobe and select output is low.
- R2: At a clock edge with slot = 1 (low-address slot), address bits 7:0 take the bus value and bits 13:8 keep their value.
- R3: At a clock edge with slot = 2 (high-address slot), address bits 13:8 take bus bits 5:0, and bus bits 7:6 are stored as the cycle kind: 00 memory read, 01 interrupt acknowledge, 10 memory write, 11 port I/O.
- R4: The address output does not change at edges with slot = 0 (idle) or slot = 3 (data), so it holds until the next address slot.
- R5: While slot = 3 and the stored kind is 00, the memory read strobe is high and every other strobe and select is low.
- R6: While slot = 3 and the stored kind is 10, the memory write strobe is high and every other strobe and select is low.
- R7: While slot = 3 and the stored kind is 11, with port number n = address bits 4:0, input select bit n is high for n from 0 to 7, output select bit n-8 is high for n from 8 to 31, and the memory strobes stay low.
- R8: While slot = 3 and the stored kind is 01, the interrupt-acknowledge strobe is high and every other strobe and select is low.
- R9: Strobes and selects are low whenever slot is not 3. The read and write strobes are never high together, and at most one strobe or select is high at any time.
- R10: After a low-address slot, a data slot that arrives before any high-address slot raises no strobe or select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot | input | 2 | Cycle slot: 0 idle, 1 low address, 2 high address, 3 data |
| bus | input | 8 | Shared address/data bus as seen by the block |
| mem_addr | output | 14 | Captured memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| int_ack | output | 1 | Interrupt-acknowledge strobe |
| port_in_sel | output | 8 | One-hot input-port select |
| port_out_sel | output | 24 | One-hot output-port select |

## Verification
The bench builds the block with its default parameters: 8 input ports, 24 output ports, an 8-bit low slot and a 6-bit high slot. With those values the five-bit port number covers exactly the 32-port space. This brings the input/output boundary at ports 7 and 8 within reach, and so are the two ends of the space, ports 0 and 31.

The bench checks partial updates in which only the low byte changes. It checks that the address holds across idle stretches, and it checks a data slot that arrives with no high-address slot before it.

// File: rtl/abus_demux.sv
module abus_demux #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 24,
  parameter int LO_W  = 8,
  parameter int HI_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          slot,
  input  logic [LO_W-1:0]     bus,
  output logic [LO_W+HI_W-1:0] mem_addr,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic                int_ack,
  output logic [N_IN-1:0]     port_in_sel,
  output logic [N_OUT-1:0]    port_out_sel
);
  localparam int AW = LO_W + HI_W;
  localparam int NP = N_IN + N_OUT;
  localparam int PW = $clog2(NP);

  localparam logic [1:0] S_IDLE = 2'd0, S_LO = 2'd1, S_HI = 2'd2, S_DATA = 2'd3;
  localparam logic [1:0] K_MRD = 2'b00, K_ACK = 2'b01, K_MWR = 2'b10, K_IO = 2'b11;

  logic [AW-1:0] addr_q;
  logic [1:0]    kind_q;
  logic          armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      kind_q  <= K_MRD;
      armed_q <= 1'b0;
    end else begin
      case (slot)
        S_LO: begin
          addr_q[LO_W-1:0] <= bus;
          armed_q          <= 1'b0;
        end
        S_HI: begin
          addr_q[AW-1:LO_W] <= bus[HI_W-1:0];
          kind_q            <= bus[LO_W-1 -: 2];
          armed_q           <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  wire live = armed_q && (slot == S_DATA);
  wire [PW-1:0] pnum = addr_q[PW-1:0];
  wire [NP-1:0] port_hot = (live && kind_q == K_IO) ? ({{(NP-1){1'b0}}, 1'b1} << pnum) : '0;

  assign mem_addr     = addr_q;
  assign mem_rd       = live && kind_q == K_MRD;
  assign mem_wr       = live && kind_q == K_MWR;
  assign int_ack      = live && kind_q == K_ACK;
  assign port_in_sel  = port_hot[N_IN-1:0];
  assign port_out_sel = port_hot[NP-1:N_IN];

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_rd, mem_wr, int_ack, port_in_sel, port_out_sel}) <= 1);

  a_r9_data_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || int_ack || (|port_in_sel) || (|port_out_sel)) |-> slot == S_DATA);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == S_IDLE || slot == S_DATA) |=> $stable(mem_addr));

  a_r3_high_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == S_HI) |=> mem_addr[AW-1:LO_W] == $past(bus[HI_W-1:0]));

  a_r2_low_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == S_LO) |=> (mem_addr[LO_W-1:0] == $past(bus)) && $stable(mem_addr[AW-1:LO_W]));

  a_r10_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == S_LO) |=> !(mem_rd || mem_wr || int_ack || (|port_in_sel) || (|port_out_sel)));

  a_r7_port_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({port_in_sel, port_out_sel}));
endmodule

// File: tb/abus_demux_tb.sv
module abus_demux_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  slot = 2'd0;
  logic [7:0]  bus = 8'h00;
  logic [13:0] mem_addr;
  logic        mem_rd, mem_wr, int_ack;
  logic [7:0]  port_in_sel;
  logic [23:0] port_out_sel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  abus_demux u_dut (
    .clk(clk), .rst_n(rst_n), .slot(slot), .bus(bus),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .int_ack(int_ack),
    .port_in_sel(port_in_sel), .port_out_sel(port_out_sel)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] strobes();
    return {29'd0, mem_rd, mem_wr, int_ack, port_in_sel, port_out_sel};
  endfunction

  function automatic logic [63:0] exp_strobes(input logic [1:0] kind, input logic [4:0] pn);
    logic [31:0] hot;
    hot = (kind == 2'b11) ? (32'd1 << pn) : 32'd0;
    return {29'd0, kind == 2'b00, kind == 2'b10, kind == 2'b01, hot[7:0], hot[31:8]};
  endfunction

  task automatic put(input logic [1:0] s, input logic [7:0] b);
    @(negedge clk);
    slot = s;
    bus = b;
  endtask

  task automatic run_cycle(input string req, input logic [7:0] lo, input logic [1:0] kind, input logic [5:0] hi);
    put(2'd1, lo);
    put(2'd2, {kind, hi});
    put(2'd3, 8'h5A);
    #1;
    chk(req, {50'd0, mem_addr}, {50'd0, hi, lo});
    chk(req, strobes(), exp_strobes(kind, lo[4:0]));
    put(2'd0, 8'h00);
    #1;
    chk({req, "/R9 idle"}, strobes(), 64'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 addr", {50'd0, mem_addr}, 64'd0);
    chk("R1 strobes", strobes(), 64'd0);
    rst_n = 1'b1;
    put(2'd3, 8'hFF);
    #1;
    chk("R1 data before cycle", strobes(), 64'd0);
    put(2'd0, 8'h00);
  endtask

  task automatic t_memory();
    run_cycle("R5 read", 8'hC3, 2'b00, 6'h2A);
    run_cycle("R6 write", 8'h3C, 2'b10, 6'h15);
    run_cycle("R8 ack", 8'h00, 2'b01, 6'h3F);
  endtask

  task automatic t_ports();
    run_cycle("R7 in0", 8'h00, 2'b11, 6'h01);
    run_cycle("R7 in7", 8'h07, 2'b11, 6'h00);
    run_cycle("R7 out8", 8'h08, 2'b11, 6'h10);
    run_cycle("R7 out31", 8'hFF, 2'b11, 6'h3E);
    run_cycle("R7 out19", 8'h13, 2'b11, 6'h02);
  endtask

  task automatic t_hold_and_partial();
    run_cycle("R3 setup", 8'h44, 2'b10, 6'h2D);
    repeat (5) put(2'd0, 8'hEE);
    #1;
    chk("R4 idle hold", {50'd0, mem_addr}, {50'd0, 6'h2D, 8'h44});
    put(2'd3, 8'h99);
    put(2'd3, 8'h77);
    #1;
    chk("R4 data hold", {50'd0, mem_addr}, {50'd0, 6'h2D, 8'h44});
    chk("R6 repeated data", strobes(), exp_strobes(2'b10, 5'd4));
    put(2'd1, 8'h91);
    put(2'd0, 8'h00);
    #1;
    chk("R2 low only", {50'd0, mem_addr}, {50'd0, 6'h2D, 8'h91});
  endtask

  task automatic t_unarmed();
    put(2'd1, 8'h05);
    put(2'd3, 8'hAA);
    #1;
    chk("R10 no strobe", strobes(), 64'd0);
    put(2'd2, 8'hC7);
    #1;
    chk("R9 high slot quiet", strobes(), 64'd0);
    put(2'd3, 8'h00);
    #1;
    chk("R3 kind+high", {50'd0, mem_addr}, {50'd0, 6'h07, 8'h05});
    chk("R7 after arm", strobes(), exp_strobes(2'b11, 5'd5));
    put(2'd0, 8'h00);
  endtask

  initial begin
    t_reset();
    t_memory();
    t_ports();
    t_hold_and_partial();
    t_unarmed();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule